// File: doc/BRIEF.md
# GPIO Port with Edge Sensing

This block is an eight-pin general-purpose I/O port with a small register interface. Software drives each pin's direction and output level, and it can change either register atomically through dedicated set, clear and toggle write addresses. No read-modify-write sequence is needed. Each pin can be marked inverted, which flips both the driven level and the sensed level.

The pin inputs pass through a two-flop synchronizer. A per-pin sense mode then turns the synchronized level into an event: both edges, rising edge only, falling edge only, or a continuous low level. Each event sets a sticky flag, and software clears a flag by writing a 1 to its bit. Two interrupt lines each have their own pin mask. An interrupt line is high while any flag whose bit is set in that line's mask is high.

The register read port is combinational on the address. Writes take effect at the clock edge on which `wr_en` is high.

Top module: `gpio_sense_port`

## Requirements
- R1: After reset, the direction, output, inversion, flag, both mask registers and every sense mode are zero. Therefore `pin_oe`, `pin_out` and `irq` are all zero.
- R2: A write to address 0 loads the direction register and a write to address 4 loads the output register. Both read back at the same address, and `pin_oe` equals the direction register.
- R3: Writes to addresses 5, 6 and 7 set, clear or toggle only those output bits whose `wdata` bit is 1. All other output bits keep their values.
- R4: Writes to addresses 1, 2 and 3 set, clear or toggle the direction bits selected by `wdata` in the same way.
- R5: The inversion register is at address 12. A pin whose inversion bit is 1 drives `pin_out` as the inverse of its output bit. The same pin has its sensed value inverted both in the input read at address 8 and in event detection.
- R6: Inputs are synchronized by two flops. A pin change made before clock edge A is visible in the input read (address 8) after the second edge B. The pin's flag is still clear after edge B and is set after the third edge C.
- R7: The sense mode of pin i is written at address 16+i in bits [1:0]. The encodings are 00 for both edges, 01 for a rising edge, 10 for a falling edge and 11 for a low level. An edge that does not match the pin's mode sets no flag.
- R8: The flag register is at address 9. Writing 1 to a bit clears that flag, and writing 0 leaves the flag unchanged. When a new event on that pin occurs in the same cycle as the clear, the flag stays set.
- R9: In low-level mode the flag is set again on every cycle while the sensed level is low, so clearing it has no lasting effect until the pin returns high.
- R10: `irq[k]` is high exactly when some pin has both its flag and its bit in mask k set. Mask 0 is at address 10 and mask 1 is at address 11.
- R11: Writes to the input read address (8) or to an unmapped address change no register and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W (5) | Register address for writes and reads |
| wdata | input | NPINS (8) | Write data |
| rdata | output | NPINS (8) | Read data for `addr`, combinational |
| pin_in | input | NPINS (8) | Raw pin levels from the pads |
| pin_out | output | NPINS (8) | Levels driven toward the pads |
| pin_oe | output | NPINS (8) | Per-pin output enable (1 = drive) |
| irq | output | 2 | Interrupt lines, one per mask |

## Verification
The hardest case to reach is a flag clear that lands in the same cycle as a fresh event on that pin. From the ports this means timing the write strobe against the synchronizer delay. The bench first sets a flag with one edge. It then drives the opposite edge half a cycle before a clock edge and waits exactly two clock edges. It places the clear write on the third edge, which is the cycle in which the event is presented. The flag must still read set afterwards. The low-level mode gives a second route to the same case, because its event persists while the pin stays low.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    typedef enum logic [1:0] {
        SNS_BOTH = 2'b00,
        SNS_RISE = 2'b01,
        SNS_FALL = 2'b10,
        SNS_LOW  = 2'b11
    } sense_e;

    localparam int unsigned A_DIR      = 0;
    localparam int unsigned A_DIR_SET  = 1;
    localparam int unsigned A_DIR_CLR  = 2;
    localparam int unsigned A_DIR_TGL  = 3;
    localparam int unsigned A_OUT      = 4;
    localparam int unsigned A_OUT_SET  = 5;
    localparam int unsigned A_OUT_CLR  = 6;
    localparam int unsigned A_OUT_TGL  = 7;
    localparam int unsigned A_IN       = 8;
    localparam int unsigned A_FLAGS    = 9;
    localparam int unsigned A_MASK0    = 10;
    localparam int unsigned A_MASK1    = 11;
    localparam int unsigned A_INV      = 12;
    localparam int unsigned A_SNS_BASE = 16;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw,
    output logic [W-1:0] synced
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_q, st_d;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = raw;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign synced = st_q.s2;
endmodule

// File: rtl/gpio_sense.sv
module gpio_sense
    import gpio_port_pkg::*;
#(
    parameter int unsigned N = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     level,
    input  logic [N-1:0][1:0] mode,
    output logic [N-1:0]     evt
);
    logic [N-1:0] prev_q, prev_d;

    always_comb prev_d = level;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end

    for (genvar i = 0; i < N; i++) begin : g_pin
        logic rise, fall;
        assign rise = level[i] & ~prev_q[i];
        assign fall = ~level[i] & prev_q[i];
        always_comb begin
            case (sense_e'(mode[i]))
                SNS_BOTH: evt[i] = rise | fall;
                SNS_RISE: evt[i] = rise;
                SNS_FALL: evt[i] = fall;
                default:  evt[i] = ~level[i];
            endcase
        end
    end
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_port_pkg::*;
#(
    parameter int unsigned N  = 8,
    parameter int unsigned AW = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     addr,
    input  logic [N-1:0]      wdata,
    input  logic [N-1:0]      evt,
    input  logic [N-1:0]      in_level,
    output logic [N-1:0]      rdata,
    output logic [N-1:0]      dir_q,
    output logic [N-1:0]      out_q,
    output logic [N-1:0]      inv_q,
    output logic [N-1:0]      flag_q,
    output logic [N-1:0]      mask0_q,
    output logic [N-1:0]      mask1_q,
    output logic [N-1:0][1:0] mode_q
);
    typedef struct packed {
        logic [N-1:0]      dir;
        logic [N-1:0]      out;
        logic [N-1:0]      inv;
        logic [N-1:0]      flag;
        logic [N-1:0]      mask0;
        logic [N-1:0]      mask1;
        logic [N-1:0][1:0] mode;
    } regs_t;

    regs_t st_q, st_d;
    logic [N-1:0] clr_bits;

    always_comb begin
        st_d     = st_q;
        clr_bits = '0;
        if (wr_en) begin
            case (addr)
                AW'(A_DIR):     st_d.dir   = wdata;
                AW'(A_DIR_SET): st_d.dir   = st_q.dir | wdata;
                AW'(A_DIR_CLR): st_d.dir   = st_q.dir & ~wdata;
                AW'(A_DIR_TGL): st_d.dir   = st_q.dir ^ wdata;
                AW'(A_OUT):     st_d.out   = wdata;
                AW'(A_OUT_SET): st_d.out   = st_q.out | wdata;
                AW'(A_OUT_CLR): st_d.out   = st_q.out & ~wdata;
                AW'(A_OUT_TGL): st_d.out   = st_q.out ^ wdata;
                AW'(A_FLAGS):   clr_bits   = wdata;
                AW'(A_MASK0):   st_d.mask0 = wdata;
                AW'(A_MASK1):   st_d.mask1 = wdata;
                AW'(A_INV):     st_d.inv   = wdata;
                default: begin
                    for (int i = 0; i < N; i++) begin
                        if (addr == AW'(A_SNS_BASE + i)) st_d.mode[i] = wdata[1:0];
                    end
                end
            endcase
        end
        st_d.flag = (st_q.flag & ~clr_bits) | evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rdata = '0;
        case (addr)
            AW'(A_DIR):   rdata = st_q.dir;
            AW'(A_OUT):   rdata = st_q.out;
            AW'(A_IN):    rdata = in_level;
            AW'(A_FLAGS): rdata = st_q.flag;
            AW'(A_MASK0): rdata = st_q.mask0;
            AW'(A_MASK1): rdata = st_q.mask1;
            AW'(A_INV):   rdata = st_q.inv;
            default: begin
                for (int i = 0; i < N; i++) begin
                    if (addr == AW'(A_SNS_BASE + i)) rdata = N'(st_q.mode[i]);
                end
            end
        endcase
    end

    assign dir_q   = st_q.dir;
    assign out_q   = st_q.out;
    assign inv_q   = st_q.inv;
    assign flag_q  = st_q.flag;
    assign mask0_q = st_q.mask0;
    assign mask1_q = st_q.mask1;
    assign mode_q  = st_q.mode;
endmodule

// File: rtl/gpio_sense_port.sv
module gpio_sense_port #(
    parameter int unsigned NPINS  = 8,
    parameter int unsigned ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [NPINS-1:0]  wdata,
    output logic [NPINS-1:0]  rdata,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  pin_oe,
    output logic [1:0]        irq
);
    logic [NPINS-1:0]      synced;
    logic [NPINS-1:0]      level;
    logic [NPINS-1:0]      evt;
    logic [NPINS-1:0]      dir_q, out_q, inv_q, flag_q, mask0_q, mask1_q;
    logic [NPINS-1:0][1:0] mode_q;

    gpio_sync #(.W(NPINS)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw    (pin_in),
        .synced (synced)
    );

    assign level = synced ^ inv_q;

    gpio_sense #(.N(NPINS)) u_sense (
        .clk   (clk),
        .rst_n (rst_n),
        .level (level),
        .mode  (mode_q),
        .evt   (evt)
    );

    gpio_regs #(.N(NPINS), .AW(ADDR_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .addr     (addr),
        .wdata    (wdata),
        .evt      (evt),
        .in_level (level),
        .rdata    (rdata),
        .dir_q    (dir_q),
        .out_q    (out_q),
        .inv_q    (inv_q),
        .flag_q   (flag_q),
        .mask0_q  (mask0_q),
        .mask1_q  (mask1_q),
        .mode_q   (mode_q)
    );

    assign pin_out = out_q ^ inv_q;
    assign pin_oe  = dir_q;
    assign irq[0]  = |(flag_q & mask0_q);
    assign irq[1]  = |(flag_q & mask1_q);
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk
    import gpio_port_pkg::*;
#(
    parameter int unsigned N  = 8,
    parameter int unsigned AW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic [AW-1:0] addr,
    input logic [N-1:0]  wdata,
    input logic [1:0]    irq,
    input logic [N-1:0]  out_q,
    input logic [N-1:0]  dir_q,
    input logic [N-1:0]  flag_q
);
    p_out_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == AW'(A_OUT_SET)) |=> out_q == $past(out_q | wdata));

    p_out_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == AW'(A_OUT_CLR)) |=> out_q == $past(out_q & ~wdata));

    p_dir_tgl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == AW'(A_DIR_TGL)) |=> dir_q == $past(dir_q ^ wdata));

    p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr == AW'(A_FLAGS)) |=> (flag_q & $past(flag_q)) == $past(flag_q));

    p_irq_needs_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (|irq) |-> (|flag_q));
endmodule

bind gpio_sense_port gpio_port_chk #(.N(NPINS), .AW(ADDR_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .addr   (addr),
    .wdata  (wdata),
    .irq    (irq),
    .out_q  (out_q),
    .dir_q  (dir_q),
    .flag_q (flag_q)
);

// File: tb/tb_gpio_sense_port.sv
`timescale 1ns/1ps
module tb_gpio_sense_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [4:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [7:0] pin_in = '0;
    logic [7:0] pin_out;
    logic [7:0] pin_oe;
    logic [1:0] irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    gpio_sense_port dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; addr = 5'(a); wdata = 8'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output logic [7:0] v);
        addr = 5'(a);
        #0.5;
        v = rdata;
    endtask

    task automatic clr_flags();
        wr(9, 8'hFF);
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        for (int a = 0; a < 24; a++) begin
            if (a != 8) begin
                rd(a, v);
                chk("R1 reg", v, 8'h00);
            end
        end
        chk("R1 pin_oe", pin_oe, 8'h00);
        chk("R1 pin_out", pin_out, 8'h00);
        chk("R1 irq", {6'b0, irq}, 8'h00);
    endtask

    task automatic t_plain();
        logic [7:0] v;
        wr(0, 8'hA5); rd(0, v);
        chk("R2 dir readback", v, 8'hA5);
        chk("R2 pin_oe", pin_oe, 8'hA5);
        wr(4, 8'h3C); rd(4, v);
        chk("R2 out readback", v, 8'h3C);
        chk("R2 pin_out", pin_out, 8'h3C);
    endtask

    task automatic t_out_atomic();
        wr(4, 8'hF0);
        wr(5, 8'h0F); chk("R3 set", pin_out, 8'hFF);
        wr(6, 8'h81); chk("R3 clear", pin_out, 8'h7E);
        wr(7, 8'hFF); chk("R3 toggle", pin_out, 8'h81);
    endtask

    task automatic t_dir_atomic();
        wr(0, 8'h00);
        wr(1, 8'h12); chk("R4 set", pin_oe, 8'h12);
        wr(3, 8'h30); chk("R4 toggle", pin_oe, 8'h22);
        wr(2, 8'h02); chk("R4 clear", pin_oe, 8'h20);
    endtask

    task automatic t_sync();
        logic [7:0] v;
        clr_flags();
        @(negedge clk); pin_in[0] = 1'b1;
        cycles(1); rd(8, v); chk("R6 input after one edge", v & 8'h01, 8'h00);
        cycles(1); rd(8, v); chk("R6 input after two edges", v & 8'h01, 8'h01);
        rd(9, v); chk("R6 flag not yet set", v & 8'h01, 8'h00);
        cycles(1); rd(9, v); chk("R6 flag after three edges", v & 8'h01, 8'h01);
        clr_flags();
        @(negedge clk); pin_in[0] = 1'b0;
        cycles(4); rd(9, v); chk("R7 both-edge mode falling", v & 8'h01, 8'h01);
    endtask

    task automatic t_rise();
        logic [7:0] v;
        wr(19, 1); clr_flags();
        @(negedge clk); pin_in[3] = 1'b1;
        cycles(3); rd(9, v); chk("R7 rise mode rising edge", v & 8'h08, 8'h08);
        clr_flags();
        @(negedge clk); pin_in[3] = 1'b0;
        cycles(4); rd(9, v); chk("R7 rise mode ignores falling", v & 8'h08, 8'h00);
    endtask

    task automatic t_fall();
        logic [7:0] v;
        wr(20, 2); clr_flags();
        @(negedge clk); pin_in[4] = 1'b1;
        cycles(4); rd(9, v); chk("R7 fall mode ignores rising", v & 8'h10, 8'h00);
        @(negedge clk); pin_in[4] = 1'b0;
        cycles(3); rd(9, v); chk("R7 fall mode falling edge", v & 8'h10, 8'h10);
    endtask

    task automatic t_low();
        logic [7:0] v;
        @(negedge clk); pin_in[5] = 1'b1;
        cycles(3);
        wr(21, 3); clr_flags();
        rd(9, v); chk("R7 low mode while high", v & 8'h20, 8'h00);
        @(negedge clk); pin_in[5] = 1'b0;
        cycles(3); rd(9, v); chk("R7 low mode sets", v & 8'h20, 8'h20);
        clr_flags();
        rd(9, v); chk("R9 low level refires after clear", v & 8'h20, 8'h20);
        @(negedge clk); pin_in[5] = 1'b1;
        cycles(4); clr_flags();
        rd(9, v); chk("R9 clears once pin high", v & 8'h20, 8'h00);
    endtask

    task automatic t_w1c();
        logic [7:0] v;
        clr_flags();
        @(negedge clk); pin_in[0] = 1'b1;
        cycles(4); rd(9, v); chk("R8 flag set", v & 8'h01, 8'h01);
        wr(9, 8'h00); rd(9, v); chk("R8 write zero keeps flag", v & 8'h01, 8'h01);
        // Event on the same cycle as the clear: drive, wait two edges, clear on third.
        @(negedge clk); pin_in[0] = 1'b0;
        cycles(2);
        wr_en = 1'b1; addr = 5'd9; wdata = 8'h01;
        @(negedge clk); wr_en = 1'b0;
        rd(9, v); chk("R8 event beats clear", v & 8'h01, 8'h01);
        wr(9, 8'h01); rd(9, v); chk("R8 clear works", v & 8'h01, 8'h00);
    endtask

    task automatic t_irq();
        clr_flags();
        wr(10, 8'h01); wr(11, 8'h08);
        chk("R10 no flags no irq", {6'b0, irq}, 8'h00);
        @(negedge clk); pin_in[0] = 1'b1;
        cycles(4); chk("R10 irq0 only", {6'b0, irq}, 8'h01);
        @(negedge clk); pin_in[3] = 1'b1;
        cycles(4); chk("R10 both lines", {6'b0, irq}, 8'h03);
        wr(9, 8'h01); chk("R10 irq0 drops with flag", {6'b0, irq}, 8'h02);
        wr(11, 8'h00); chk("R10 mask1 removed", {6'b0, irq}, 8'h00);
    endtask

    task automatic t_inv();
        logic [7:0] v;
        wr(22, 2);
        wr(12, 8'h40);
        chk("R5 inverted drive", pin_out, 8'hC1);
        rd(8, v); chk("R5 inverted sense read", v & 8'h40, 8'h40);
        clr_flags();
        @(negedge clk); pin_in[6] = 1'b1;
        cycles(3); rd(9, v); chk("R5 inverted fall detect", v & 8'h40, 8'h40);
        rd(8, v); chk("R5 inverted high reads low", v & 8'h40, 8'h00);
    endtask

    task automatic t_unmapped();
        logic [7:0] v;
        wr(31, 8'hFF); wr(8, 8'hFF);
        rd(0, v);  chk("R11 dir unchanged", v, 8'h20);
        rd(4, v);  chk("R11 out unchanged", v, 8'h81);
        rd(10, v); chk("R11 mask0 unchanged", v, 8'h01);
        rd(12, v); chk("R11 inv unchanged", v, 8'h40);
        chk("R11 pin_out unchanged", pin_out, 8'hC1);
    endtask

    initial begin
        for (int i = 0; i < 100000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        cycles(3);
        rst_n = 1'b1;
        cycles(2);
        t_reset();
        t_plain();
        t_out_atomic();
        t_dir_atomic();
        t_sync();
        t_rise();
        t_fall();
        t_low();
        t_w1c();
        t_irq();
        t_inv();
        t_unmapped();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule